// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block produces the periodic interrupt line of a real-time clock. It runs from the 32.768 kHz timebase and holds its own binary sub-second prescaler. The prescaler paces the seconds-increment strobe that the calendar counters consume. It also supplies the two square-wave taps used by the pulse modes. A 3-bit mode code selects one of three behaviours: a static output level, a free-running 50% square wave, or a latched low level. The latched level is raised by a calendar event and released only when software clears the flag.

The calendar counters sit outside the block. They report, for the increment about to happen, which fields will roll over: seconds at 59, minutes at 59, hours at 23, and last day of the month. The block ANDs these carries along a chain to recognise the minute, hour and month boundaries. A write to the seconds register clears the whole prescaler, so the second is re-phased from the moment of the write.

Top module: `rtc_pint_gen`

## Requirements
- R1: After the asynchronous reset, the mode is 000, `int_no` is high and `flag_o` is 0. While the mode is 000 the output stays high and the flag stays 0.
- R2: In mode 001 `int_no` is held low on every cycle.
- R3: In mode 010 `int_no` is a square wave with a period of 2^(DIV_W-1) cycles. It is low for the first half of each period, counted from the prescaler value zero.
- R4: In mode 011 `int_no` is a square wave with a period of 2^DIV_W cycles. It is low for the first half of each period.
- R5: `sec_inc_o` is a one-cycle strobe. It fires LAG_CYC cycles after each falling edge of the 1 Hz tap, that is, once per 2^DIV_W cycles. The first strobe after a reset or a seconds write comes 2^DIV_W + LAG_CYC cycles later.
- R6: In mode 100, each seconds increment sets the flag and drives `int_no` low at the same clock edge. Both hold until the flag is cleared.
- R7: Mode 101 latches only on an increment with the seconds carry. Mode 110 needs both the seconds and minutes carries. Mode 111 needs all four carries: seconds, minutes, hours and end of month.
- R8: In a level mode, a `flag_clr_i` pulse clears the flag and returns `int_no` high on the next edge. If an event occurs in the same cycle, the event wins.
- R9: In modes 010 and 011, `flag_o` equals the inverse of `int_no`, so a flag clear there has no visible effect.
- R10: A `sec_wr_i` pulse resets the prescaler to zero. In a pulse mode, `int_no` is low on the cycle after the write, and the square wave restarts from the beginning of its period.
- R11: A change of the mode code takes effect at the next edge and clears any latched flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz timebase clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Interrupt mode code |
| flag_clr_i | input | 1 | Software write of 0 to the flag |
| sec_wr_i | input | 1 | Software rewrote the seconds register |
| sec_carry_i | input | 1 | Seconds field wraps on the next increment |
| min_carry_i | input | 1 | Minutes field wraps on the next increment |
| hr_carry_i | input | 1 | Hours field wraps on the next increment |
| mon_carry_i | input | 1 | Date is the last day of the month |
| int_no | output | 1 | Active-low interrupt output |
| flag_o | output | 1 | Readable interrupt flag |
| sec_inc_o | output | 1 | Seconds-increment strobe to the time counters |

## Verification
Several properties are checked on every cycle:
- the static levels of modes 000 and 001;
- the single-cycle width of the seconds strobe;
- the tie between pin and flag, which inverts in both the level and the pulse families;
- the holding and release of a latched flag;
- the low output right after a seconds write;
- the flag clearing on a mode change.

The periodic behaviour can only be shown by the bench's sweeps, which run a cycle model against the design:
- the exact period and phase of both square waves;
- the placement of the seconds strobe after its prescaler wrap;
- the first-second delay after reset or a write;
- the carry qualification of the minute, hour and month events.

// File: rtl/rtc_pint_pkg.sv
package rtc_pint_pkg;

   typedef enum logic [2:0] {
      PI_OFF   = 3'd0,
      PI_LOW   = 3'd1,
      PI_2HZ   = 3'd2,
      PI_1HZ   = 3'd3,
      PI_SEC   = 3'd4,
      PI_MIN   = 3'd5,
      PI_HOUR  = 3'd6,
      PI_MONTH = 3'd7
   } pint_mode_e;

   localparam int unsigned N_CARRY = 4;

   function automatic logic is_pulse(input logic [2:0] m);
      return (m == PI_2HZ) || (m == PI_1HZ);
   endfunction

   function automatic logic is_level(input logic [2:0] m);
      return m[2];
   endfunction

endpackage

// File: rtl/rtc_pint_prescaler.sv
module rtc_pint_prescaler #(
   parameter int unsigned DIV_W   = 15,
   parameter int unsigned LAG_CYC = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   output logic             tap_fast_o,
   output logic             tap_slow_o,
   output logic             sec_inc_o
);

   localparam logic [DIV_W-1:0] MAX_V = {DIV_W{1'b1}};
   localparam logic [DIV_W-1:0] LAG_V = DIV_W'(LAG_CYC);
   localparam int unsigned HALF_FAST  = 2 ** (DIV_W - 2);

   if (DIV_W < 3) begin : g_bad_width
      $error("rtc_pint_prescaler: DIV_W must be at least 3");
   end
   if (LAG_CYC == 0 || LAG_CYC >= HALF_FAST) begin : g_bad_lag
      $error("rtc_pint_prescaler: LAG_CYC must lie inside the first fast half period");
   end

   logic [DIV_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == MAX_V) begin
            armed_q <= 1'b1;
         end
      end
   end

   assign tap_fast_o = cnt_q[DIV_W-2];
   assign tap_slow_o = cnt_q[DIV_W-1];
   assign sec_inc_o  = armed_q && (cnt_q == LAG_V);

endmodule

// File: rtl/rtc_pint_event.sv
module rtc_pint_event
   import rtc_pint_pkg::*;
(
   input  logic               inc_i,
   input  logic [N_CARRY-1:0] carry_i,
   input  logic [2:0]         mode_i,
   output logic               evt_o
);

   // chain[k] = increment qualified by the first k carries
   logic [N_CARRY:0] chain;
   assign chain[0] = inc_i;

   for (genvar k = 0; k < N_CARRY; k++) begin : g_chain
      assign chain[k+1] = chain[k] & carry_i[k];
   end

   always_comb begin
      unique case (mode_i)
         PI_SEC:   evt_o = chain[0];
         PI_MIN:   evt_o = chain[1];
         PI_HOUR:  evt_o = chain[2];
         PI_MONTH: evt_o = chain[N_CARRY];
         default:  evt_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/rtc_pint_outstage.sv
module rtc_pint_outstage
   import rtc_pint_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] mode_i,
   input  logic       flag_clr_i,
   input  logic       evt_i,
   input  logic       tap_fast_i,
   input  logic       tap_slow_i,
   output logic [2:0] mode_q_o,
   output logic       int_no,
   output logic       flag_o
);

   logic [2:0] mode_q;
   logic       flag_q;
   logic       flag_d;
   logic       mode_chg;

   assign mode_chg = (mode_i != mode_q);

   always_comb begin
      flag_d = 1'b0;
      if (!mode_chg && is_level(mode_q)) begin
         if (evt_i)           flag_d = 1'b1;
         else if (flag_clr_i) flag_d = 1'b0;
         else                 flag_d = flag_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= PI_OFF;
         flag_q <= 1'b0;
      end else begin
         mode_q <= mode_i;
         flag_q <= flag_d;
      end
   end

   always_comb begin
      unique case (mode_q)
         PI_OFF:  int_no = 1'b1;
         PI_LOW:  int_no = 1'b0;
         PI_2HZ:  int_no = tap_fast_i;
         PI_1HZ:  int_no = tap_slow_i;
         default: int_no = !flag_q;
      endcase
   end

   assign flag_o   = is_pulse(mode_q) ? !int_no : flag_q;
   assign mode_q_o = mode_q;

endmodule

// File: rtl/rtc_pint_gen.sv
module rtc_pint_gen
   import rtc_pint_pkg::*;
#(
   parameter int unsigned DIV_W   = 15,
   parameter int unsigned LAG_CYC = 3
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [2:0] mode_i,
   input  logic       flag_clr_i,
   input  logic       sec_wr_i,
   input  logic       sec_carry_i,
   input  logic       min_carry_i,
   input  logic       hr_carry_i,
   input  logic       mon_carry_i,
   output logic       int_no,
   output logic       flag_o,
   output logic       sec_inc_o
);

   logic               tap_fast;
   logic               tap_slow;
   logic               lvl_evt;
   logic [2:0]         mode_q;
   logic [N_CARRY-1:0] carries;

   assign carries = {mon_carry_i, hr_carry_i, min_carry_i, sec_carry_i};

   rtc_pint_prescaler #(
      .DIV_W   (DIV_W),
      .LAG_CYC (LAG_CYC)
   ) u_presc (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (sec_wr_i),
      .tap_fast_o (tap_fast),
      .tap_slow_o (tap_slow),
      .sec_inc_o  (sec_inc_o)
   );

   rtc_pint_event u_event (
      .inc_i   (sec_inc_o),
      .carry_i (carries),
      .mode_i  (mode_q),
      .evt_o   (lvl_evt)
   );

   rtc_pint_outstage u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_i     (mode_i),
      .flag_clr_i (flag_clr_i),
      .evt_i      (lvl_evt),
      .tap_fast_i (tap_fast),
      .tap_slow_i (tap_slow),
      .mode_q_o   (mode_q),
      .int_no     (int_no),
      .flag_o     (flag_o)
   );

endmodule

// File: rtl/rtc_pint_chk.sv
module rtc_pint_chk
   import rtc_pint_pkg::*;
(
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] mode_i,
   input logic       flag_clr_i,
   input logic       sec_wr_i,
   input logic       int_no,
   input logic       flag_o,
   input logic       sec_inc_o,
   input logic [2:0] mode_q,
   input logic       lvl_evt
);

   p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == PI_OFF) |-> (int_no && !flag_o));

   p_const_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q == PI_LOW) |-> !int_no);

   p_inc_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sec_inc_o |=> !sec_inc_o);

   p_level_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_level(mode_q) |-> (int_no == !flag_o));

   p_level_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_level(mode_q) && flag_o && !flag_clr_i && (mode_i == mode_q)) |=> flag_o);

   p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_level(mode_q) && flag_clr_i && !lvl_evt && (mode_i == mode_q)) |=> int_no);

   p_pulse_mirror_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_pulse(mode_q) |-> (flag_o == !int_no));

   p_wr_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sec_wr_i && is_pulse(mode_q) && (mode_i == mode_q)) |=> !int_no);

   p_mode_chg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_i != mode_q) && !is_pulse(mode_i)) |=> !flag_o);

endmodule

bind rtc_pint_gen rtc_pint_chk chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mode_i     (mode_i),
   .flag_clr_i (flag_clr_i),
   .sec_wr_i   (sec_wr_i),
   .int_no     (int_no),
   .flag_o     (flag_o),
   .sec_inc_o  (sec_inc_o),
   .mode_q     (mode_q),
   .lvl_evt    (lvl_evt)
);

// File: tb/rtc_pint_gen_tb_top.sv
`timescale 1ns/1ps
module rtc_pint_gen_tb_top;

   localparam int DW  = 4;
   localparam int LAG = 3;
   localparam int PER = 2 ** DW;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'd0;
   logic       fclr = 1'b0;
   logic       swr = 1'b0;
   logic       c_s = 1'b0, c_m = 1'b0, c_h = 1'b0, c_d = 1'b0;
   logic       int_n, flag, inc;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   rtc_pint_gen #(.DIV_W(DW), .LAG_CYC(LAG)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .flag_clr_i(fclr),
      .sec_wr_i(swr), .sec_carry_i(c_s), .min_carry_i(c_m),
      .hr_carry_i(c_h), .mon_carry_i(c_d),
      .int_no(int_n), .flag_o(flag), .sec_inc_o(inc));

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
      end
   endtask

   // reference model built from the requirements
   int         m_cnt = 0;
   logic       m_arm = 1'b0;
   logic       m_flag = 1'b0;
   logic [2:0] m_mode = 3'd0;

   function automatic logic m_inc();
      return m_arm && (m_cnt == LAG);
   endfunction

   function automatic logic m_int();
      case (m_mode)
         3'd0: return 1'b1;
         3'd1: return 1'b0;
         3'd2: return (m_cnt % (PER / 2)) >= (PER / 4);
         3'd3: return m_cnt >= (PER / 2);
         default: return !m_flag;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_arm <= 1'b0; m_flag <= 1'b0; m_mode <= 3'd0;
      end else begin
         logic ev;
         ev = m_inc() && ((m_mode == 3'd4) ||
                          (m_mode == 3'd5 && c_s) ||
                          (m_mode == 3'd6 && c_s && c_m) ||
                          (m_mode == 3'd7 && c_s && c_m && c_h && c_d));
         if (swr) begin
            m_cnt <= 0; m_arm <= 1'b0;
         end else begin
            m_cnt <= (m_cnt + 1) % PER;
            if (m_cnt == PER - 1) m_arm <= 1'b1;
         end
         if (mode != m_mode)  m_flag <= 1'b0;
         else if (!m_mode[2]) m_flag <= 1'b0;
         else if (ev)         m_flag <= 1'b1;
         else if (fclr)       m_flag <= 1'b0;
         m_mode <= mode;
      end
   end

   // continuous comparison, sampled away from the edge
   always @(posedge clk) begin
      cyc++;
      #2;
      if (rst_n && !done) begin
         string rq, rf;
         case (m_mode)
            3'd0: begin rq = "R1"; rf = "R1"; end
            3'd1: begin rq = "R2"; rf = "R2"; end
            3'd2: begin rq = "R3"; rf = "R9"; end
            3'd3: begin rq = "R4"; rf = "R9"; end
            3'd4: begin rq = "R6"; rf = "R8"; end
            default: begin rq = "R7"; rf = "R8"; end
         endcase
         chk(rq, int_n, m_int());
         chk(rf, flag, (m_mode == 3'd2 || m_mode == 3'd3) ? !m_int() : m_flag);
         chk("R5", inc, m_inc());
      end
   end

   // watchdog
   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] lfsr = 8'hA5;
      #1;
      chk("R1", int_n, 1'b1);
      chk("R1", flag, 1'b0);
      chk("R1", inc, 1'b0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int m = 0; m < 8; m++) begin
         @(negedge clk);
         mode = 3'(m);
         @(negedge clk);
         if (m >= 4) chk("R11", flag, 1'b0);
         for (int i = 0; i < 6 * PER; i++) begin
            @(negedge clk);
            if (i == 41 && (m == 2 || m == 3)) chk("R10", int_n, 1'b0);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            c_s  = lfsr[0] | (i >= 3 * PER);
            c_m  = lfsr[2] | (i >= 3 * PER);
            c_h  = lfsr[4] | (i >= 4 * PER);
            c_d  = lfsr[6] | (i >= 4 * PER);
            fclr = (i % 13 == 12);
            swr  = (i == 40);
         end
         fclr = 1'b0; swr = 1'b0;
      end
      // R8: clear and event in the same cycle, event wins (mode 100)
      @(negedge clk);
      mode = 3'd4;
      fclr = 1'b1;
      repeat (2 * PER) @(negedge clk);
      fclr = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule